// File: doc/BRIEF.md
# Register Rename and Issue Unit

This block sits between instruction decode and a set of reservation stations. Each cycle it can take one decoded instruction, in program order, and place it into a free entry of the station group that serves the instruction's functional-unit type (arithmetic or multiply). It does not wait for source operands. Each source register is looked up in a register status table. A register with no outstanding producer supplies its value. A register that is still waiting supplies the tag of the station entry that will produce it. The destination register is then marked as owned by the new instruction's station tag.

The unit also watches the common result bus. A broadcast result is written into the architectural register only if that register still names the broadcasting tag, and that register's pending mark is then cleared. A broadcast also releases its station entry for reuse. A source that names the tag being broadcast in the same cycle picks up the broadcast value directly.

Top module: `rn_issue_unit`

## Requirements
- R1: After a synchronous reset, iss_valid is 0, every station entry is free (in_ready is 1 for either unit type), and every register reads as value 0 with no pending producer.
- R2: When in_valid and in_ready are both 1 at a clock edge, the next cycle shows iss_valid=1 with iss_op equal to the accepted in_op. Otherwise iss_valid is 0 in the next cycle. At most one instruction is accepted per cycle, and accepted instructions appear in the order they were offered.
- R3: A station tag is 3 bits: bit 2 is 1, bit 1 is the unit type (0 arithmetic, 1 multiply) and bit 0 is the entry index, so 4..7 are the four entries. Tag 0 means "no pending producer". The lowest-indexed free entry of the requested type is chosen, and an entry is never handed out twice while it is still outstanding.
- R4: in_ready is 0 while both entries of the requested unit type are outstanding, and nothing is issued then. An entry becomes free at the edge that ends the cycle in which its tag is broadcast, so it can be allocated from the next cycle.
- R5: A source register with no pending producer is issued with tag 0 and the register's current value.
- R6: A source register with a pending producer is issued with that producer's tag and value field 0.
- R7: On issue, the destination register's pending tag becomes the new instruction's tag, so a reader in the very next cycle receives that tag.
- R8: A broadcast whose tag equals a register's pending tag writes the broadcast value into that register and clears its tag.
- R9: A broadcast whose tag differs from a register's current pending tag (a younger producer now owns it) leaves that register's value and tag unchanged.
- R10: A source whose pending tag equals the tag broadcast in the same cycle is issued with tag 0 and the broadcast value.
- R11: An instruction that reads and writes the same register reads the mapping that existed before its own retag.
- R12: If an issue retags a register in the same cycle that a broadcast clears it, the register ends up pending on the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_ready | output | 1 | A free entry exists for the offered unit type |
| in_unit | input | 1 | Unit type: 0 arithmetic, 1 multiply |
| in_op | input | 4 | Operation code, passed through |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| in_dst | input | 3 | Destination register |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | 3 | Tag of the broadcasting station entry |
| cdb_value | input | 16 | Broadcast result |
| iss_valid | output | 1 | Issue record valid (registered) |
| iss_op | output | 4 | Issued operation code |
| iss_tag | output | 3 | Station entry receiving the instruction |
| iss_a_tag | output | 3 | Producer tag of source A, 0 if value present |
| iss_a_val | output | 16 | Value of source A, 0 if pending |
| iss_b_tag | output | 3 | Producer tag of source B, 0 if value present |
| iss_b_val | output | 16 | Value of source B, 0 if pending |

## Verification
An issue and a result broadcast can land in the same cycle and touch the same state. The broadcast may name a tag that the issuing instruction's source is waiting on, or the register the instruction retags, or the entry the allocator would like to reuse. Directed sequences set up each of these collisions on purpose, and a long random run lets broadcasts of outstanding tags fall on arbitrary issue cycles. Every cycle is judged against a bench model. The model resolves the source read first, then the broadcast write, then the retag and the allocation.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int DEF_UNITS   = 2;
  localparam int DEF_ENTRIES = 2;
  localparam int DEF_REGS    = 8;
  localparam int DEF_DATA_W  = 16;
  localparam int DEF_OP_W    = 4;

  typedef enum logic [0:0] {
    UNIT_ARITH = 1'b0,
    UNIT_MUL   = 1'b1
  } unit_e;
endpackage

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int UNITS   = rn_pkg::DEF_UNITS,
  parameter int ENTRIES = rn_pkg::DEF_ENTRIES,
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOTS  = UNITS * ENTRIES
) (
  input  logic [SLOTS-1:0]  busy_i,
  input  logic [UNIT_W-1:0] unit_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [UNITS-1:0] unit_found;
  logic [IDX_W-1:0] unit_idx [UNITS];

  // one lowest-free picker per unit type
  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    logic             f;
    logic [IDX_W-1:0] ix;
    always_comb begin
      f  = 1'b0;
      ix = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
        if (!busy_i[u*ENTRIES + e]) begin
          f  = 1'b1;
          ix = IDX_W'(e);
        end
      end
    end
    assign unit_found[u] = f;
    assign unit_idx[u]   = ix;
  end

  assign found_o = unit_found[unit_i];
  assign idx_o   = unit_idx[unit_i];
endmodule

// File: rtl/rn_regstat.sv
module rn_regstat #(
  parameter int REGS   = rn_pkg::DEF_REGS,
  parameter int DATA_W = rn_pkg::DEF_DATA_W,
  parameter int TAG_W  = 3,
  parameter int RD     = 2,
  localparam int RW    = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [RD-1:0][RW-1:0]    rd_addr_i,
  output logic [RD-1:0][TAG_W-1:0] rd_tag_o,
  output logic [RD-1:0][DATA_W-1:0] rd_val_o,
  input  logic                     cdb_valid_i,
  input  logic [TAG_W-1:0]         cdb_tag_i,
  input  logic [DATA_W-1:0]        cdb_val_i,
  input  logic                     wr_en_i,
  input  logic [RW-1:0]            wr_addr_i,
  input  logic [TAG_W-1:0]         wr_tag_i
);
  logic [DATA_W-1:0] val_q [REGS];
  logic [TAG_W-1:0]  tag_q [REGS];

  // broadcast write first, retag last so the retag wins on the same register
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < REGS; r++) begin
        val_q[r] <= '0;
        tag_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < REGS; r++) begin
        if (cdb_valid_i && (tag_q[r] != '0) && (tag_q[r] == cdb_tag_i)) begin
          val_q[r] <= cdb_val_i;
          tag_q[r] <= '0;
        end
        if (wr_en_i && (wr_addr_i == RW'(r)))
          tag_q[r] <= wr_tag_i;
      end
    end
  end

  for (genvar p = 0; p < RD; p++) begin : g_rd
    logic [TAG_W-1:0] t;
    assign t = tag_q[rd_addr_i[p]];
    always_comb begin
      if (t == '0) begin
        rd_tag_o[p] = '0;
        rd_val_o[p] = val_q[rd_addr_i[p]];
      end else if (cdb_valid_i && (t == cdb_tag_i)) begin
        rd_tag_o[p] = '0;
        rd_val_o[p] = cdb_val_i;
      end else begin
        rd_tag_o[p] = t;
        rd_val_o[p] = '0;
      end
    end
  end
endmodule

// File: rtl/rn_issue_unit.sv
module rn_issue_unit #(
  parameter int UNITS   = rn_pkg::DEF_UNITS,
  parameter int ENTRIES = rn_pkg::DEF_ENTRIES,
  parameter int REGS    = rn_pkg::DEF_REGS,
  parameter int DATA_W  = rn_pkg::DEF_DATA_W,
  parameter int OP_W    = rn_pkg::DEF_OP_W,
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int RW     = (REGS > 1) ? $clog2(REGS) : 1,
  localparam int TAG_W  = UNIT_W + IDX_W + 1,
  localparam int SLOTS  = UNITS * ENTRIES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [UNIT_W-1:0] in_unit,
  input  logic [OP_W-1:0]   in_op,
  input  logic [RW-1:0]     in_src_a,
  input  logic [RW-1:0]     in_src_b,
  input  logic [RW-1:0]     in_dst,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              iss_valid,
  output logic [OP_W-1:0]   iss_op,
  output logic [TAG_W-1:0]  iss_tag,
  output logic [TAG_W-1:0]  iss_a_tag,
  output logic [DATA_W-1:0] iss_a_val,
  output logic [TAG_W-1:0]  iss_b_tag,
  output logic [DATA_W-1:0] iss_b_val
);
  logic [SLOTS-1:0]          busy_q;
  logic                      alloc_found;
  logic [IDX_W-1:0]          alloc_idx;
  logic                      fire;
  logic [TAG_W-1:0]          new_tag;
  logic [SLOTS-1:0]          set_mask, clr_mask;
  logic [1:0][RW-1:0]        rd_addr;
  logic [1:0][TAG_W-1:0]     rd_tag;
  logic [1:0][DATA_W-1:0]    rd_val;

  rn_alloc #(.UNITS(UNITS), .ENTRIES(ENTRIES)) u_alloc (
    .busy_i  (busy_q),
    .unit_i  (in_unit),
    .found_o (alloc_found),
    .idx_o   (alloc_idx)
  );

  assign in_ready = alloc_found;
  assign fire     = in_valid && alloc_found;
  assign new_tag  = {1'b1, in_unit, alloc_idx};
  assign rd_addr  = {in_src_b, in_src_a};

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (fire)
      set_mask[{in_unit, alloc_idx}] = 1'b1;
    if (cdb_valid && cdb_tag[TAG_W-1])
      clr_mask[cdb_tag[TAG_W-2:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= '0;
    else     busy_q <= (busy_q & ~clr_mask) | set_mask;
  end

  rn_regstat #(.REGS(REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .RD(2)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .rd_addr_i   (rd_addr),
    .rd_tag_o    (rd_tag),
    .rd_val_o    (rd_val),
    .cdb_valid_i (cdb_valid),
    .cdb_tag_i   (cdb_tag),
    .cdb_val_i   (cdb_value),
    .wr_en_i     (fire),
    .wr_addr_i   (in_dst),
    .wr_tag_i    (new_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid <= 1'b0;
      iss_op    <= '0;
      iss_tag   <= '0;
      iss_a_tag <= '0;
      iss_a_val <= '0;
      iss_b_tag <= '0;
      iss_b_val <= '0;
    end else begin
      iss_valid <= fire;
      if (fire) begin
        iss_op    <= in_op;
        iss_tag   <= new_tag;
        iss_a_tag <= rd_tag[0];
        iss_a_val <= rd_val[0];
        iss_b_tag <= rd_tag[1];
        iss_b_val <= rd_val[1];
      end
    end
  end
endmodule

// File: rtl/rn_issue_unit_chk.sv
module rn_issue_unit_chk #(
  parameter int UNITS   = rn_pkg::DEF_UNITS,
  parameter int ENTRIES = rn_pkg::DEF_ENTRIES,
  parameter int DATA_W  = rn_pkg::DEF_DATA_W,
  parameter int OP_W    = rn_pkg::DEF_OP_W,
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int TAG_W  = UNIT_W + IDX_W + 1,
  localparam int SLOTS  = UNITS * ENTRIES
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [UNIT_W-1:0] in_unit,
  input logic [OP_W-1:0]   in_op,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic              iss_valid,
  input logic [OP_W-1:0]   iss_op,
  input logic [TAG_W-1:0]  iss_tag,
  input logic [TAG_W-1:0]  iss_a_tag,
  input logic [DATA_W-1:0] iss_a_val,
  input logic [TAG_W-1:0]  iss_b_tag,
  input logic [DATA_W-1:0] iss_b_val
);
  // entries seen on the issue output and not yet broadcast
  logic [SLOTS-1:0] seen_q;
  logic             unit_full;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (iss_valid && iss_tag[TAG_W-2:0] == (TAG_W-1)'(s)) seen_q[s] <= 1'b1;
        if (cdb_valid && cdb_tag[TAG_W-1] && cdb_tag[TAG_W-2:0] == (TAG_W-1)'(s)) seen_q[s] <= 1'b0;
      end
    end
  end

  always_comb begin
    unit_full = 1'b1;
    for (int e = 0; e < ENTRIES; e++)
      if (!seen_q[in_unit*ENTRIES + e]) unit_full = 1'b0;
  end

  // R2
  accept_issues_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (iss_valid && iss_op == $past(in_op)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> !iss_valid);

  // R3
  tag_unit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (iss_tag[TAG_W-1] && iss_tag[TAG_W-2 -: UNIT_W] == $past(in_unit)));

  // R3
  no_double_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !seen_q[iss_tag[TAG_W-2:0]]);

  // R4
  full_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    unit_full |-> !in_ready);

  // R6
  pending_a_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_a_tag != '0) |-> (iss_a_val == '0));

  // R6
  pending_b_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_b_tag != '0) |-> (iss_b_val == '0));
endmodule

bind rn_issue_unit rn_issue_unit_chk #(
  .UNITS(UNITS), .ENTRIES(ENTRIES), .DATA_W(DATA_W), .OP_W(OP_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_unit(in_unit), .in_op(in_op), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
  .iss_valid(iss_valid), .iss_op(iss_op), .iss_tag(iss_tag),
  .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
  .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val)
);

// File: tb/rn_issue_unit_test.sv
module rn_issue_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready;
  logic [0:0]  in_unit;
  logic [3:0]  in_op;
  logic [2:0]  in_src_a, in_src_b, in_dst;
  logic        cdb_valid;
  logic [2:0]  cdb_tag;
  logic [15:0] cdb_value;
  logic        iss_valid;
  logic [3:0]  iss_op;
  logic [2:0]  iss_tag, iss_a_tag, iss_b_tag;
  logic [15:0] iss_a_val, iss_b_val;

  rn_issue_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_unit(in_unit), .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst(in_dst), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_tag(iss_tag),
    .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
    .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the register status table and entry occupancy
  logic [15:0] m_val [8];
  logic [2:0]  m_tag [8];
  logic [3:0]  m_busy;
  int          n_tests = 0;
  int          n_fail  = 0;
  string       ctx     = "";

  task automatic chk(string req, int unsigned act, int unsigned exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void src_read(input logic [2:0] r, input bit cv, input logic [2:0] ct,
                                   input logic [15:0] cval, output logic [2:0] t,
                                   output logic [15:0] v, output string lbl);
    if (m_tag[r] == 3'd0) begin
      t = 3'd0; v = m_val[r]; lbl = "R5";
    end else if (cv && m_tag[r] == ct) begin
      t = 3'd0; v = cval; lbl = "R10";
    end else begin
      t = m_tag[r]; v = 16'd0; lbl = "R6";
    end
  endfunction

  task automatic step(bit iv, bit u, logic [3:0] op, logic [2:0] a, logic [2:0] b,
                      logic [2:0] d, bit cv, logic [2:0] ct, logic [15:0] cval);
    bit exp_ready, fire, idx;
    logic [2:0] etag, at, bt;
    logic [15:0] av, bv;
    string la, lb;
    in_valid = iv; in_unit = u; in_op = op; in_src_a = a; in_src_b = b; in_dst = d;
    cdb_valid = cv; cdb_tag = ct; cdb_value = cval;
    #1;
    exp_ready = !m_busy[{u, 1'b0}] || !m_busy[{u, 1'b1}];
    chk({"R4", ctx}, in_ready, exp_ready, "in_ready");
    fire = iv && exp_ready;
    idx  = m_busy[{u, 1'b0}];
    etag = {1'b1, u, idx};
    src_read(a, cv, ct, cval, at, av, la);
    src_read(b, cv, ct, cval, bt, bv, lb);
    @(posedge clk);
    #1;
    chk({"R2", ctx}, iss_valid, fire, "iss_valid");
    if (fire) begin
      chk({"R2", ctx}, iss_op, op, "iss_op");
      chk({"R3", ctx}, iss_tag, etag, "iss_tag");
      chk({la, ctx}, iss_a_tag, at, "iss_a_tag");
      chk({la, ctx}, iss_a_val, av, "iss_a_val");
      chk({lb, ctx}, iss_b_tag, bt, "iss_b_tag");
      chk({lb, ctx}, iss_b_val, bv, "iss_b_val");
    end
    // model update: broadcast write, then retag and allocation
    if (cv) begin
      for (int r = 0; r < 8; r++)
        if (m_tag[r] != 3'd0 && m_tag[r] == ct) begin
          m_val[r] = cval;
          m_tag[r] = 3'd0;
        end
      m_busy[ct[1:0]] = 1'b0;
    end
    if (fire) begin
      m_tag[d] = etag;
      m_busy[{u, idx}] = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R2 watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    in_valid = 0; in_unit = 0; in_op = 0; in_src_a = 0; in_src_b = 0; in_dst = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
    for (int r = 0; r < 8; r++) begin m_val[r] = 16'd0; m_tag[r] = 3'd0; end
    m_busy = 4'd0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    chk("R1", iss_valid, 0, "iss_valid after reset");
    chk("R1", in_ready, 1, "in_ready after reset");

    ctx = " R1";  step(1, 0, 4'd1, 3'd1, 3'd2, 3'd1, 0, 3'd0, 16'h0);
    ctx = " R7";  step(1, 0, 4'd2, 3'd1, 3'd1, 3'd3, 0, 3'd0, 16'h0);
    ctx = " R8";  step(0, 0, 4'd0, 3'd0, 3'd0, 3'd0, 1, 3'd4, 16'h0005);
                  step(1, 1, 4'd3, 3'd1, 3'd3, 3'd2, 0, 3'd0, 16'h0);
    ctx = " R9";  step(1, 0, 4'd4, 3'd0, 3'd0, 3'd3, 0, 3'd0, 16'h0);
                  step(1, 0, 4'd5, 3'd3, 3'd3, 3'd4, 1, 3'd5, 16'h0077);
                  step(1, 1, 4'd6, 3'd3, 3'd0, 3'd5, 0, 3'd0, 16'h0);
    ctx = " R10"; step(1, 0, 4'd7, 3'd3, 3'd5, 3'd6, 1, 3'd4, 16'h0123);
    ctx = " R4";  step(1, 1, 4'd8, 3'd0, 3'd0, 3'd0, 0, 3'd0, 16'h0);
                  step(1, 1, 4'd8, 3'd0, 3'd0, 3'd0, 1, 3'd6, 16'h0044);
                  step(1, 1, 4'd9, 3'd2, 3'd0, 3'd1, 0, 3'd0, 16'h0);
    ctx = " R11"; step(1, 0, 4'd10, 3'd1, 3'd1, 3'd1, 1, 3'd5, 16'h0099);
                  step(1, 0, 4'd11, 3'd1, 3'd0, 3'd0, 0, 3'd0, 16'h0);
    ctx = " R12"; step(0, 0, 4'd0, 3'd0, 3'd0, 3'd0, 1, 3'd5, 16'h0010);
                  step(1, 0, 4'd12, 3'd0, 3'd0, 3'd1, 1, 3'd4, 16'h0055);
                  step(1, 0, 4'd13, 3'd1, 3'd0, 3'd2, 0, 3'd0, 16'h0);

    ctx = "";
    for (int n = 0; n < 3000; n++) begin
      bit cv;
      logic [1:0] slot;
      cv = 0; slot = 2'd0;
      if (m_busy != 4'd0 && ($urandom % 3) != 0) begin
        slot = 2'($urandom);
        for (int k = 0; k < 4 && !m_busy[slot]; k++) slot = slot + 2'd1;
        cv = 1;
      end
      step(($urandom % 4) != 0, 1'($urandom), 4'($urandom), 3'($urandom), 3'($urandom),
           3'($urandom), cv, {1'b1, slot}, 16'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule